// File: doc/BRIEF.md
# Indirect Extended RAM Port

This block lets a processor reach a large internal byte RAM through three registers in an extended register bank. Two pointer registers hold the RAM address as a low byte and a high byte. A third register is the data window. Reading the window returns the byte at the pointer, and writing it stores a byte at the pointer. When burst mode is on, the pointer steps forward by one after every window access, so a block of bytes can be streamed with repeated accesses to one location.

Requests arrive on an 8-bit register bus that uses a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Every accepted read produces exactly one response on a valid/ready output channel, one cycle after acceptance. Writes produce no response. The response stays on `rsp_data` with `rsp_valid` high until the consumer raises `rsp_ready`. While a response is waiting and `rsp_ready` is low, `req_ready` is low, which back-pressures the request side. At most one response is ever outstanding.

A bank bit in the general control register at 0Ah (bit 4) chooses which bank is decoded. The pointer, window and burst-control registers are visible only when this bit is 1. The RAM holds 2^ADDR_W bytes and is built from synchronous storage.

Top module: `xram_port`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, the pointer is 0, the burst enable is 0 and the register at 0Ah reads 00h.
- R2: Every accepted read produces `rsp_valid`=1 in the next cycle with the addressed value. Accepted writes produce no response. Reads of undecoded locations return 00h. Location 0Ah stores and returns all 8 bits in either bank.
- R3: In the extended bank, 50h holds pointer bits 7:0 and 51h holds the pointer bits from 8 up to ADDR_W-1, right-aligned. Bits of 51h beyond the RAM width are dropped on write and read as 0.
- R4: In the extended bank, a write to 53h stores the byte at the pointer. A read of 53h returns the RAM byte at the pointer as it was before that access.
- R5: With burst enable (bit 5 of 4Ah, extended bank) at 0, window accesses leave the pointer unchanged. 4Ah reads back burst enable in bit 5 and 0 in all other bits.
- R6: With burst enable at 1, each accepted window read or write advances the pointer by one after the access. A read returns the byte at the pointer value from before the step.
- R7: The pointer wraps from 2^ADDR_W-1 to 0.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `req_ready` is 0 and `rsp_data` holds steady. In every other case `req_ready` is 1.
- R9: With bank bit 0 (bit 4 of 0Ah), writes to 4Ah, 50h, 51h and 53h have no effect and reads of them return 00h.
- R10: A pointer write takes effect at once, so the next window access uses the new pointer with no extra step left over from an earlier burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A register request is present |
| req_ready | output | 1 | The block can accept a request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register location |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response is present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response data |

## Verification
A pointer that steps when it should not, or fails to step, shows up on the very next window read as a byte from the neighbouring location. It also shows up on the next read of 50h or 51h. A bank bit that is decoded wrongly exposes pointer or window values in bank 0, or hides them in bank 1, on the first read that follows. A broken response buffer either loses `rsp_data` while `rsp_ready` is low or lets a second request through in that same cycle, and the cycle-by-cycle comparison of `req_ready`, `rsp_valid` and `rsp_data` catches this within one clock.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam logic [7:0] LOC_CTRL  = 8'h0A;
  localparam logic [7:0] LOC_XCTL  = 8'h4A;
  localparam logic [7:0] LOC_PTRLO = 8'h50;
  localparam logic [7:0] LOC_PTRHI = 8'h51;
  localparam logic [7:0] LOC_WIN   = 8'h53;
  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CTRL,
    TGT_XCTL,
    TGT_PTRLO,
    TGT_PTRHI,
    TGT_WIN
  } tgt_e;
endpackage

// File: rtl/xram_decode.sv
module xram_decode
  import xram_pkg::*;
(
  input  logic [7:0] addr,
  input  logic       bank,
  output tgt_e       tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (addr == LOC_CTRL) begin
      tgt = TGT_CTRL;
    end else if (bank) begin
      unique case (addr)
        LOC_XCTL:  tgt = TGT_XCTL;
        LOC_PTRLO: tgt = TGT_PTRLO;
        LOC_PTRHI: tgt = TGT_PTRHI;
        LOC_WIN:   tgt = TGT_WIN;
        default:   tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/xram_regs.sv
module xram_regs
  import xram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              wr,
  input  tgt_e              tgt,
  input  logic [7:0]        wdata,
  output logic [7:0]        ctrl,
  output logic              burst,
  output logic [ADDR_W-1:0] ptr,
  output logic [7:0]        rd_val
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0] hi_view;
  logic       step;

  generate
    if (HI_W == 8) begin : g_full_hi
      assign hi_view = ptr[ADDR_W-1:8];
    end else begin : g_part_hi
      assign hi_view = {{(8-HI_W){1'b0}}, ptr[ADDR_W-1:8]};
    end
  endgenerate

  assign step = acc && (tgt == TGT_WIN) && burst;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      burst <= 1'b0;
      ptr   <= '0;
    end else begin
      if (acc && wr) begin
        unique case (tgt)
          TGT_CTRL:  ctrl <= wdata;
          TGT_XCTL:  burst <= wdata[BURST_BIT];
          TGT_PTRLO: ptr[7:0] <= wdata;
          TGT_PTRHI: ptr[ADDR_W-1:8] <= wdata[HI_W-1:0];
          default: ;
        endcase
      end
      if (step) ptr <= ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end

  always_comb begin
    unique case (tgt)
      TGT_CTRL:  rd_val = ctrl;
      TGT_XCTL:  rd_val = 8'(burst) << BURST_BIT;
      TGT_PTRLO: rd_val = ptr[7:0];
      TGT_PTRHI: rd_val = hi_view;
      default:   rd_val = 8'h00;
    endcase
  end
endmodule

// File: rtl/xram_array.sv
module xram_array #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/xram_rsp.sv
module xram_rsp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       from_ram,
  input  logic [7:0] reg_val,
  input  logic [7:0] ram_q,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       can_take
);
  logic       sel_ram;
  logic [7:0] held;

  assign can_take = !rsp_valid || rsp_ready;
  assign rsp_data = sel_ram ? ram_q : held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      sel_ram   <= 1'b0;
      held      <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      sel_ram   <= from_ram;
      held      <= reg_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/xram_port.sv
module xram_port
  import xram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_wr,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_data
);
  tgt_e              tgt;
  logic              acc;
  logic [7:0]        ctrl;
  logic              burst;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rd_val;
  logic [7:0]        ram_q;
  logic              bank;
  logic              win;

  assign bank = ctrl[BANK_BIT];
  assign acc  = req_valid && req_ready;
  assign win  = acc && (tgt == TGT_WIN);

  xram_decode u_dec (
    .addr (req_addr),
    .bank (bank),
    .tgt  (tgt)
  );

  xram_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .wr     (req_wr),
    .tgt    (tgt),
    .wdata  (req_wdata),
    .ctrl   (ctrl),
    .burst  (burst),
    .ptr    (ptr),
    .rd_val (rd_val)
  );

  xram_array #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (win && req_wr),
    .re    (win && !req_wr),
    .addr  (ptr),
    .wdata (req_wdata),
    .q     (ram_q)
  );

  xram_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc && !req_wr),
    .from_ram  (tgt == TGT_WIN),
    .reg_val   (rd_val),
    .ram_q     (ram_q),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .can_take  (req_ready)
  );
endmodule

// File: rtl/xram_port_chk.sv
module xram_port_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_wr,
  input logic [7:0]        req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic [7:0]        ctrl,
  input logic              burst,
  input logic [ADDR_W-1:0] ptr
);
  logic win_acc;
  assign win_acc = req_valid && req_ready && ctrl[4] && (req_addr == 8'h53);

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R8
  AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_wr) |=> rsp_valid); // R2
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_wr) |=> !rsp_valid); // R2
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(ptr)); // R5
  AST_SINGLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !burst) |=> $stable(ptr)); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && burst) |=> (ptr == ($past(ptr) + {{(ADDR_W-1){1'b0}}, 1'b1}))); // R6
endmodule

bind xram_port xram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ctrl      (ctrl),
  .burst     (burst),
  .ptr       (ptr)
);

// File: tb/xram_port_tb.sv
module xram_port_tb_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0, rsp_ready = 1'b1;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_data;

  always #2 clk = ~clk;

  xram_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int vectors = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  byte unsigned m_ctrl;
  bit           m_burst;
  int           m_ptr;
  byte unsigned m_ram [DEPTH];
  bit           e_valid;
  byte unsigned e_data;
  string        e_tag;

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_bank();
    return m_ctrl[4];
  endfunction

  function automatic string auto_tag(input byte unsigned a);
    if (a == 8'h0A) return "R2";
    if (!m_bank()) return "R9";
    if (a == 8'h50 || a == 8'h51) return "R3";
    if (a == 8'h53) return m_burst ? "R6" : "R4";
    if (a == 8'h4A) return "R5";
    return "R2";
  endfunction

  function automatic byte unsigned m_read(input byte unsigned a);
    if (a == 8'h0A) return m_ctrl;
    if (!m_bank()) return 8'h00;
    case (a)
      8'h4A: return m_burst ? 8'h20 : 8'h00;
      8'h50: return byte'(m_ptr % 256);
      8'h51: return byte'(m_ptr / 256);
      8'h53: return m_ram[m_ptr];
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input bit v, input bit w, input byte unsigned a,
                      input byte unsigned d, input bit rr, input string tag);
    bit acc;
    bit e_ready;
    @(negedge clk);
    cmp((e_tag == "") ? "R2" : e_tag, rsp_valid, e_valid);
    if (e_valid) cmp((e_tag == "") ? "R2" : e_tag, rsp_data, e_data);
    req_valid = v; req_wr = w; req_addr = a; req_wdata = d; rsp_ready = rr;
    #1;
    e_ready = !e_valid || rr;
    cmp("R8", req_ready, e_ready);
    acc = v && e_ready;
    if (e_valid && rr) e_valid = 0;
    if (acc) begin
      if (!w) begin
        e_valid = 1;
        e_data = m_read(a);
        e_tag = (tag == "") ? auto_tag(a) : tag;
      end else if (a == 8'h0A) begin
        m_ctrl = d;
      end else if (m_bank()) begin
        case (a)
          8'h4A: m_burst = d[5];
          8'h50: m_ptr = (m_ptr / 256) * 256 + d;
          8'h51: m_ptr = (d % (DEPTH / 256)) * 256 + (m_ptr % 256);
          8'h53: m_ram[m_ptr] = d;
          default: ;
        endcase
      end
      if (m_bank() && a == 8'h53 && m_burst) m_ptr = (m_ptr + 1) % DEPTH;
    end
  endtask

  task automatic wr(input byte unsigned a, input byte unsigned d, input string tag);
    step(1, 1, a, d, 1, tag);
  endtask
  task automatic rd(input byte unsigned a, input string tag);
    step(1, 0, a, 8'h00, 1, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 8'h00, 8'h00, 1, tag);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_ctrl = 0; m_burst = 0; m_ptr = 0; e_valid = 0; e_data = 0; e_tag = "";
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values seen through the ports
    idle("R1");
    rd(8'h0A, "R1");
    wr(8'h0A, 8'h10, "R2");
    rd(8'h50, "R1");
    rd(8'h51, "R1");
    rd(8'h4A, "R1");
    // fill RAM in burst mode (R6, R7 wraps back to 0 at the end)
    wr(8'h4A, 8'h20, "R5");
    wr(8'h50, 8'h00, "R3");
    wr(8'h51, 8'h00, "R3");
    for (int i = 0; i < DEPTH; i++) wr(8'h53, byte'((i * 37 + 11) % 256), "R6");
    rd(8'h50, "R7");
    rd(8'h51, "R7");
    // R7: explicit wrap from the last byte
    wr(8'h50, 8'hFF, "R3");
    wr(8'h51, 8'hFF, "R3");
    rd(8'h51, "R3");
    rd(8'h53, "R7");
    rd(8'h50, "R7");
    rd(8'h53, "R7");
    // R10: pointer rewrite during burst, next access uses new pointer
    rd(8'h53, "R6");
    wr(8'h50, 8'h40, "R10");
    rd(8'h53, "R10");
    rd(8'h53, "R10");
    // R5: single mode does not move
    wr(8'h4A, 8'hDF, "R5");
    rd(8'h4A, "R5");
    rd(8'h53, "R5");
    wr(8'h53, 8'h5A, "R5");
    rd(8'h53, "R5");
    rd(8'h50, "R5");
    // R9: bank 0 hides and ignores extended registers
    wr(8'h0A, 8'h00, "R9");
    wr(8'h50, 8'h77, "R9");
    wr(8'h53, 8'hEE, "R9");
    wr(8'h4A, 8'h20, "R9");
    rd(8'h50, "R9");
    rd(8'h53, "R9");
    rd(8'h4A, "R9");
    wr(8'h0A, 8'hFF, "R9");
    rd(8'h50, "R9");
    rd(8'h53, "R9");
    rd(8'h4A, "R9");
    rd(8'h0A, "R2");
    // R8: back-pressure on the response
    step(1, 0, 8'h53, 0, 0, "R8");
    step(1, 0, 8'h50, 0, 0, "R8");
    step(1, 0, 8'h50, 0, 0, "R8");
    step(1, 0, 8'h50, 0, 1, "R8");
    idle("R8");
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      byte unsigned a;
      byte unsigned d = byte'($urandom_range(0, 255));
      if (r < 40) a = 8'h53;
      else if (r < 55) a = 8'h50;
      else if (r < 65) a = 8'h51;
      else if (r < 72) a = 8'h4A;
      else if (r < 76) begin a = 8'h0A; d = (d & 8'hEF) | (($urandom_range(0, 9) < 8) ? 8'h10 : 8'h00); end
      else a = byte'($urandom_range(0, 127));
      step($urandom_range(0, 9) < 8, $urandom_range(0, 1), a, d,
           $urandom_range(0, 9) < 7, "");
    end
    idle("R2");
    idle("R2");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule